// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-programmed SPI master for serial flash. Software writes a command word holding up to four opcode and address bytes. For a write it may also fill a shared 256-byte data buffer. It then writes a control word. That control write starts one transaction framed by chip select.

The engine shifts out the command bytes. It then either streams buffer bytes out or captures incoming bytes into the same buffer. At the end it sets a completion flag, which software clears by writing zero. The engine knows nothing of flash opcodes: command length, direction and byte count all come from the control word.

The bus is a plain 32-bit register port with a byte address, a write strobe, write data and read data. Writes are always 32 bits wide. A read returns the addressed byte in bits 7:0, so byte-wide reads work at any address. The register map uses byte offsets:

| Offset | Register |
|---|---|
| 0x000 | Clock control |
| 0x004 | Status |
| 0x008 | Command |
| 0x00C | Control |
| 0x100–0x1FF | Data buffer |

The sequencer is a state machine with these states:

- `SQ_IDLE`: chip select is high.
- `SQ_CMD_KICK`: hands one command byte to the bit shifter.
- `SQ_CMD_WAIT`: waits for that byte to finish.
- `SQ_DAT_KICK`: hands one data byte to the bit shifter.
- `SQ_DAT_WAIT`: waits for that byte to finish; in a read it stores the captured byte.
- `SQ_CS_HOLD`: chip select is high again for one SCK period before completion is flagged.

Its transitions are:

- IDLE→CMD_KICK on an accepted control write.
- CMD_KICK→CMD_WAIT always.
- CMD_WAIT→CMD_KICK when a byte ends and more command bytes remain.
- CMD_WAIT→DAT_KICK after the last command byte when the count is nonzero.
- CMD_WAIT→CS_HOLD after the last command byte when the count is zero.
- DAT_KICK→DAT_WAIT always.
- DAT_WAIT→DAT_KICK when a byte ends and more data bytes remain.
- DAT_WAIT→CS_HOLD after the last data byte.
- CS_HOLD→IDLE once the hold time has elapsed, which is also when status is set.

Top module: `sflash_cmd_engine`

## Requirements
- R1: Command bytes go out in this order: command bits 7:0 first, then bits 31:24, then 23:16, then 15:8. Control bits 17:16 hold the command length minus one, so 1 to 4 bytes are sent.
- R2: In a write transaction (control bit 18 clear), the control count (bits 8:0) of buffer bytes follows the command bytes. Data byte k is taken from buffer word k/4, most significant byte first: bits 31:24, then 23:16, 15:8 and 7:0.
- R3: In a read transaction (control bit 18 set), captured byte n is stored in bits 8*(n%4)+7:8*(n%4) of buffer word n/4. A read at buffer byte address 0x100+n returns that byte in bits 7:0.
- R4: A control write starts the transaction. With a count of zero, only the command bytes are sent, whatever the value of bit 18, and the buffer is left unchanged.
- R5: A count above 256 is treated as 256.
- R6: Status reads 0 after reset and reads 1 once a transaction completes. Writing 0 clears it; writing a nonzero value leaves it set.
- R7: While a transaction runs, writes to the command register, the control register or the buffer are ignored. In particular, an ignored control write starts no new transaction.
- R8: SCK idles low (mode 0). Its half period is D clock cycles, where D is clock-control bits 31:28; a value of 0 acts as 1. The value is taken when the transaction starts.
- R9: Chip select stays high for at least one SCK period (2*D cycles) after the last bit before status is set.
- R10: After reset, chip select is high, SCK is low, and clock control reads 0x10000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 9 | Byte address; 0x100–0x1FF is the buffer |
| bus_we_i | input | 1 | 32-bit write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, addressed byte in bits 7:0 |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
The assertions assume each bus write lasts a single cycle and that control words carry counts within the 9-bit field. They also assume the flash side drives MISO stably between SCK falling edges. The bench drives every bus access on the falling clock edge and holds each write for exactly one cycle. It clears status before each launch and polls status rather than counting cycles. A flash model built on SCK edges shifts MISO only on falling edges. Busy-time writes are issued only after a long transfer has begun, so they always land while the engine is active.

// File: rtl/sfce_pkg.sv
package sfce_pkg;
    localparam int unsigned SEL_CLK  = 0;
    localparam int unsigned SEL_STAT = 1;
    localparam int unsigned SEL_CMD  = 2;
    localparam int unsigned SEL_CTRL = 3;
    localparam int unsigned CTRL_RD_BIT  = 18;
    localparam int unsigned CTRL_LEN_LSB = 16;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD_KICK,
        SQ_CMD_WAIT,
        SQ_DAT_KICK,
        SQ_DAT_WAIT,
        SQ_CS_HOLD
    } seq_state_e;
endpackage

// File: rtl/sfce_bit_shifter.sv
module sfce_bit_shifter #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       tx_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic             miso_i,
    output logic             sck_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [7:0]       rx_o
);
    logic             busy_q, sck_q, done_q;
    logic [7:0]       sh_q, rx_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] hcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            hcnt_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    sh_q   <= tx_i;
                    bit_q  <= '0;
                    hcnt_q <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (hcnt_q == half_i - DIV_W'(1)) begin
                hcnt_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso_i};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                hcnt_q <= hcnt_q + DIV_W'(1);
            end
        end
    end

    assign sck_o  = sck_q;
    assign mosi_o = sh_q[7];
    assign busy_o = busy_q;
    assign done_o = done_q;
    assign rx_o   = rx_q;

    // R8
    sck_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck_q) |-> $past(busy_q));
    // R1
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_q);
endmodule

// File: rtl/sfce_byte_store.sv
module sfce_byte_store #(
    parameter int BYTES = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we_i,
    input  logic [$clog2(BYTES)-3:0]  bus_widx_i,
    input  logic [31:0]               bus_wdata_i,
    input  logic [$clog2(BYTES)-3:0]  bus_ridx_i,
    output logic [31:0]               bus_rdata_o,
    input  logic [$clog2(BYTES)-1:0]  eng_ridx_i,
    output logic [7:0]                eng_rbyte_o,
    input  logic                      eng_we_i,
    input  logic [$clog2(BYTES)-1:0]  eng_widx_i,
    input  logic [7:0]                eng_wbyte_i
);
    localparam int WORDS = BYTES / 4;
    localparam int BI_W  = $clog2(BYTES);

    logic [3:0][7:0] eng_lane_w;

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [7:0] lane_q [WORDS];
        always_ff @(posedge clk) begin
            if (bus_we_i)
                lane_q[bus_widx_i] <= bus_wdata_i[8*l +: 8];
            else if (eng_we_i && (eng_widx_i[1:0] == 2'(l)))
                lane_q[eng_widx_i[BI_W-1:2]] <= eng_wbyte_i;
        end
        assign bus_rdata_o[8*l +: 8] = lane_q[bus_ridx_i];
        assign eng_lane_w[l]         = lane_q[eng_ridx_i[BI_W-1:2]];
    end

    assign eng_rbyte_o = eng_lane_w[eng_ridx_i[1:0]];

    // R7
    port_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_i && eng_we_i));
endmodule

// File: rtl/sfce_sequencer.sv
module sfce_sequencer
    import sfce_pkg::*;
#(
    parameter int BYTES = 256,
    parameter int DIV_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go_i,
    input  logic [31:0]               cmd_i,
    input  logic [1:0]                ncmd_m1_i,
    input  logic                      rd_i,
    input  logic [$clog2(BYTES):0]    cnt_i,
    input  logic [DIV_W-1:0]          half_i,
    input  logic                      sh_done_i,
    input  logic [7:0]                sh_rx_i,
    input  logic [7:0]                buf_byte_i,
    output logic                      busy_o,
    output logic                      cs_n_o,
    output logic                      sh_start_o,
    output logic [7:0]                sh_tx_o,
    output logic [$clog2(BYTES)-1:0]  buf_ridx_o,
    output logic                      buf_we_o,
    output logic [$clog2(BYTES)-1:0]  buf_widx_o,
    output logic [7:0]                buf_wbyte_o,
    output logic                      done_o
);
    localparam int BI_W   = $clog2(BYTES);
    localparam int CNT_W  = BI_W + 1;
    localparam int HOLD_W = DIV_W + 1;

    seq_state_e        state_q, nxt_state;
    logic [31:0]       cmd_q;
    logic [1:0]        ncmd_q, idx_q;
    logic              rd_q;
    logic [CNT_W-1:0]  cnt_q, dcnt_q;
    logic [HOLD_W-1:0] hold_q, hold_last;

    assign hold_last = {half_i, 1'b0} - HOLD_W'(1);

    always_comb begin
        nxt_state = state_q;
        unique case (state_q)
            SQ_IDLE:     if (go_i) nxt_state = SQ_CMD_KICK;
            SQ_CMD_KICK: nxt_state = SQ_CMD_WAIT;
            SQ_CMD_WAIT: if (sh_done_i) begin
                if (idx_q != ncmd_q)      nxt_state = SQ_CMD_KICK;
                else if (cnt_q == '0)     nxt_state = SQ_CS_HOLD;
                else                      nxt_state = SQ_DAT_KICK;
            end
            SQ_DAT_KICK: nxt_state = SQ_DAT_WAIT;
            SQ_DAT_WAIT: if (sh_done_i) begin
                if (dcnt_q == cnt_q - CNT_W'(1)) nxt_state = SQ_CS_HOLD;
                else                             nxt_state = SQ_DAT_KICK;
            end
            SQ_CS_HOLD:  if (hold_q == hold_last) nxt_state = SQ_IDLE;
            default:     nxt_state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cmd_q   <= '0;
            ncmd_q  <= '0;
            rd_q    <= 1'b0;
            cnt_q   <= '0;
            idx_q   <= '0;
            dcnt_q  <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= nxt_state;
            unique case (state_q)
                SQ_IDLE: if (go_i) begin
                    cmd_q  <= cmd_i;
                    ncmd_q <= ncmd_m1_i;
                    rd_q   <= rd_i;
                    cnt_q  <= cnt_i;
                    idx_q  <= '0;
                    dcnt_q <= '0;
                    hold_q <= '0;
                end
                SQ_CMD_WAIT: if (sh_done_i && (idx_q != ncmd_q)) idx_q <= idx_q + 2'd1;
                SQ_DAT_WAIT: if (sh_done_i) dcnt_q <= dcnt_q + CNT_W'(1);
                SQ_CS_HOLD:  hold_q <= hold_q + HOLD_W'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        cs_n_o      = (state_q == SQ_IDLE) || (state_q == SQ_CS_HOLD);
        busy_o      = (state_q != SQ_IDLE);
        sh_start_o  = (state_q == SQ_CMD_KICK) || (state_q == SQ_DAT_KICK);
        sh_tx_o     = 8'h00;
        if (state_q == SQ_CMD_KICK) begin
            unique case (idx_q)
                2'd0:    sh_tx_o = cmd_q[7:0];
                2'd1:    sh_tx_o = cmd_q[31:24];
                2'd2:    sh_tx_o = cmd_q[23:16];
                default: sh_tx_o = cmd_q[15:8];
            endcase
        end else if (state_q == SQ_DAT_KICK) begin
            sh_tx_o = rd_q ? 8'h00 : buf_byte_i;
        end
        buf_ridx_o  = {dcnt_q[BI_W-1:2], ~dcnt_q[1:0]};
        buf_we_o    = (state_q == SQ_DAT_WAIT) && sh_done_i && rd_q;
        buf_widx_o  = dcnt_q[BI_W-1:0];
        buf_wbyte_o = sh_rx_i;
        done_o      = (state_q == SQ_CS_HOLD) && (hold_q == hold_last);
    end

    // R1
    cmd_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE) |-> (idx_q <= ncmd_q));
    // R5
    dcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DAT_WAIT) |-> ((dcnt_q < cnt_q) && (cnt_q <= CNT_W'(BYTES))));
    // R9
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (cs_n_o && !busy_o));
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sfce_pkg::*;
#(
    parameter int BUF_BYTES = 256,
    parameter int DIV_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(BUF_BYTES):0]     bus_addr_i,
    input  logic                           bus_we_i,
    input  logic [31:0]                    bus_wdata_i,
    output logic [31:0]                    bus_rdata_o,
    output logic                           sck_o,
    output logic                           mosi_o,
    input  logic                           miso_i,
    output logic                           cs_n_o
);
    localparam int ADDR_W = $clog2(BUF_BYTES) + 1;
    localparam int BI_W   = $clog2(BUF_BYTES);
    localparam int WI_W   = BI_W - 2;
    localparam int CNT_W  = BI_W + 1;
    localparam logic [31:0] CLK_RST = 32'(1) << (32 - DIV_W);

    logic [31:0]      clk_q, cmd_q, ctrl_q;
    logic             stat_q;
    logic [DIV_W-1:0] half_q, div_fld;
    logic             in_buf, seq_busy, seq_done, go;
    logic [1:0]       sel;
    logic [CNT_W-1:0] cnt_raw, cnt_sat;
    logic [31:0]      buf_rword, rword;

    logic             sh_start, sh_busy, sh_done;
    logic [7:0]       sh_tx, sh_rx, eng_rbyte, eng_wbyte;
    logic [BI_W-1:0]  eng_ridx, eng_widx;
    logic             eng_we;

    assign in_buf  = bus_addr_i[ADDR_W-1];
    assign sel     = bus_addr_i[3:2];
    assign go      = bus_we_i && !in_buf && (sel == 2'(SEL_CTRL)) && !seq_busy;
    assign cnt_raw = bus_wdata_i[CNT_W-1:0];
    assign cnt_sat = (cnt_raw > CNT_W'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : cnt_raw;
    assign div_fld = clk_q[31 -: DIV_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q  <= CLK_RST;
            cmd_q  <= '0;
            ctrl_q <= '0;
            stat_q <= 1'b0;
            half_q <= DIV_W'(1);
        end else begin
            if (bus_we_i && !in_buf) begin
                if (sel == 2'(SEL_CLK)) clk_q <= bus_wdata_i;
                if ((sel == 2'(SEL_CMD)) && !seq_busy) cmd_q <= bus_wdata_i;
                if (go) ctrl_q <= bus_wdata_i;
            end
            if (go) half_q <= (div_fld == '0) ? DIV_W'(1) : div_fld;
            if (seq_done)
                stat_q <= 1'b1;
            else if (bus_we_i && !in_buf && (sel == 2'(SEL_STAT)) && (bus_wdata_i == '0))
                stat_q <= 1'b0;
        end
    end

    sfce_byte_store #(.BYTES(BUF_BYTES)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (bus_we_i && in_buf && !seq_busy),
        .bus_widx_i  (bus_addr_i[BI_W-1:2]),
        .bus_wdata_i (bus_wdata_i),
        .bus_ridx_i  (bus_addr_i[BI_W-1:2]),
        .bus_rdata_o (buf_rword),
        .eng_ridx_i  (eng_ridx),
        .eng_rbyte_o (eng_rbyte),
        .eng_we_i    (eng_we),
        .eng_widx_i  (eng_widx),
        .eng_wbyte_i (eng_wbyte)
    );

    sfce_sequencer #(.BYTES(BUF_BYTES), .DIV_W(DIV_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .cmd_i       (cmd_q),
        .ncmd_m1_i   (bus_wdata_i[CTRL_LEN_LSB +: 2]),
        .rd_i        (bus_wdata_i[CTRL_RD_BIT]),
        .cnt_i       (cnt_sat),
        .half_i      (half_q),
        .sh_done_i   (sh_done),
        .sh_rx_i     (sh_rx),
        .buf_byte_i  (eng_rbyte),
        .busy_o      (seq_busy),
        .cs_n_o      (cs_n_o),
        .sh_start_o  (sh_start),
        .sh_tx_o     (sh_tx),
        .buf_ridx_o  (eng_ridx),
        .buf_we_o    (eng_we),
        .buf_widx_o  (eng_widx),
        .buf_wbyte_o (eng_wbyte),
        .done_o      (seq_done)
    );

    sfce_bit_shifter #(.DIV_W(DIV_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .tx_i    (sh_tx),
        .half_i  (half_q),
        .miso_i  (miso_i),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o),
        .busy_o  (sh_busy),
        .done_o  (sh_done),
        .rx_o    (sh_rx)
    );

    always_comb begin
        if (in_buf) rword = buf_rword;
        else begin
            unique case (sel)
                2'(SEL_CLK):  rword = clk_q;
                2'(SEL_STAT): rword = {31'b0, stat_q};
                2'(SEL_CMD):  rword = cmd_q;
                default:      rword = ctrl_q;
            endcase
        end
    end
    assign bus_rdata_o = rword >> {bus_addr_i[1:0], 3'b000};

    // R8
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);
    // R8
    shift_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !cs_n_o);
    // R6
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> stat_q);
    // R6
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && !in_buf && (sel == 2'(SEL_STAT)) && (bus_wdata_i == '0) && !seq_done)
        |=> !stat_q);
    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && bus_we_i && !in_buf && (sel == 2'(SEL_CMD))) |=> $stable(cmd_q));
endmodule

// File: tb/sflash_cmd_engine_tb_top.sv
module sflash_cmd_engine_tb_top;
    localparam logic [8:0] A_CLK  = 9'h000;
    localparam logic [8:0] A_STAT = 9'h004;
    localparam logic [8:0] A_CMD  = 9'h008;
    localparam logic [8:0] A_CTRL = 9'h00C;
    localparam logic [8:0] A_BUF  = 9'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sck, mosi, miso, cs_n;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sflash_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sck_o(sck),
        .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
    );

    // flash model
    int gbit = 0;
    int mbit = 0;
    logic [7:0] tx_cap [0:299];
    logic [7:0] cur_resp;

    function automatic logic [7:0] resp(int g);
        return 8'((g * 29 + 90) & 255);
    endfunction

    always @(negedge sck) gbit = gbit + 1;
    always @(posedge sck) begin
        if (mbit < 2400) tx_cap[mbit / 8][7 - (mbit % 8)] = mosi;
        mbit = mbit + 1;
    end
    always_comb cur_resp = resp(gbit / 8);
    assign miso = cur_resp[7 - (gbit % 8)];

    // timing monitor
    int   cyc = 0;
    logic sck_d = 1'b0;
    logic cs_d = 1'b1;
    int   last_rise = -1;
    int   min_per = 1000000;
    int   cs_rise_cyc = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (sck && !sck_d) begin
            if (last_rise >= 0 && (cyc - last_rise) < min_per) min_per = cyc - last_rise;
            last_rise = cyc;
        end
        if (cs_n && !cs_d) cs_rise_cyc = cyc;
        sck_d = sck;
        cs_d = cs_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 d = rdata;
    endtask

    task automatic launch(input logic [31:0] ctrl);
        wr(A_STAT, 32'h0);
        gbit = 0; mbit = 0; min_per = 1000000; last_rise = -1;
        wr(A_CTRL, ctrl);
    endtask

    task automatic wait_done(output int seen);
        logic [31:0] v;
        seen = -1;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, v);
            if (v != 0) begin seen = cyc; break; end
        end
        if (seen < 0) check(1'b0, "R6", "completion timeout", 0, 1);
    endtask

    function automatic logic [7:0] wbyte(logic [31:0] w, int k);
        return w[8 * (3 - (k % 4)) +: 8];
    endfunction

    function automatic logic [31:0] fillw(int i);
        return 32'(i) * 32'h0404_0404 + 32'h1003_0201;
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        check(cs_n == 1'b1, "R10", "cs_n at reset", 32'(cs_n), 1);
        check(sck == 1'b0, "R10", "sck at reset", 32'(sck), 0);
        rd(A_STAT, v);
        check(v == 0, "R6", "status at reset", v, 0);
        rd(A_CLK, v);
        check(v == 32'h1000_0000, "R10", "clock control at reset", v, 32'h1000_0000);
    endtask

    task automatic t_cmd_only;
        int s; logic [31:0] v;
        wr(A_CMD, 32'h4433_2211);
        launch(32'h0003_0000);
        wait_done(s);
        check(mbit == 32, "R4", "bit count, command only", mbit, 32);
        check({tx_cap[0], tx_cap[1], tx_cap[2], tx_cap[3]} == 32'h1144_3322,
              "R1", "four-byte command order",
              {tx_cap[0], tx_cap[1], tx_cap[2], tx_cap[3]}, 32'h1144_3322);
        check(min_per == 2, "R8", "sck period at D=1", min_per, 2);
        check(s - cs_rise_cyc + 1 >= 2, "R9", "cs high before status", s - cs_rise_cyc + 1, 2);
        rd(A_STAT, v);
        check(v == 1, "R6", "status after completion", v, 1);
    endtask

    task automatic t_short_cmd;
        int s;
        wr(A_CMD, 32'h9988_77AB);
        launch(32'h0001_0000);
        wait_done(s);
        check(mbit == 16, "R1", "two-byte command length", mbit, 16);
        check({tx_cap[0], tx_cap[1]} == 16'hAB99, "R1", "two-byte command order",
              {tx_cap[0], tx_cap[1]}, 16'hAB99);
    endtask

    task automatic t_write;
        int s; int bad = 0;
        logic [31:0] w0 = 32'hA1B2_C3D4;
        logic [31:0] w1 = 32'h0102_0304;
        wr(A_BUF, w0);
        wr(A_BUF + 9'h4, w1);
        wr(A_CMD, 32'h0000_0002);
        launch(32'h0000_0006);
        wait_done(s);
        check(mbit == 56, "R2", "write bit count", mbit, 56);
        check(tx_cap[0] == 8'h02, "R2", "opcode before data", tx_cap[0], 8'h02);
        for (int k = 0; k < 6; k++)
            if (tx_cap[1 + k] != wbyte(k < 4 ? w0 : w1, k)) bad++;
        check(bad == 0, "R2", "write bytes MSB-first per word", bad, 0);
    endtask

    task automatic t_read;
        int s; logic [31:0] v, e;
        wr(A_CMD, 32'h0B0A_0903);
        launch(32'h0007_0007);
        wait_done(s);
        check(mbit == 88, "R3", "read bit count", mbit, 88);
        check({tx_cap[0], tx_cap[1], tx_cap[2], tx_cap[3]} == 32'h030B_0A09,
              "R1", "read command order",
              {tx_cap[0], tx_cap[1], tx_cap[2], tx_cap[3]}, 32'h030B_0A09);
        rd(A_BUF, v);
        e = {resp(7), resp(6), resp(5), resp(4)};
        check(v == e, "R3", "read word 0 little-endian", v, e);
        rd(A_BUF + 9'h4, v);
        e = {8'h01, resp(10), resp(9), resp(8)};
        check(v == e, "R3", "read word 1 partial", v, e);
        rd(A_BUF + 9'h5, v);
        check(v[7:0] == resp(9), "R3", "byte read at offset 5", v[7:0], resp(9));
    endtask

    task automatic t_rd_zero;
        int s; logic [31:0] v;
        wr(A_BUF, 32'h5566_7788);
        wr(A_CMD, 32'h0000_0005);
        launch(32'h0004_0000);
        wait_done(s);
        check(mbit == 8, "R4", "read with zero count sends command only", mbit, 8);
        rd(A_BUF, v);
        check(v == 32'h5566_7788, "R4", "buffer untouched", v, 32'h5566_7788);
    endtask

    task automatic t_saturate;
        int s; int bad = 0;
        for (int i = 0; i < 64; i++) wr(A_BUF + 9'(4 * i), fillw(i));
        wr(A_CMD, 32'h0000_0002);
        launch(32'h0000_012C);
        wait_done(s);
        check(mbit == 257 * 8, "R5", "count 300 saturates", mbit, 257 * 8);
        for (int k = 0; k < 256; k++)
            if (tx_cap[1 + k] != wbyte(fillw(k / 4), k)) bad++;
        check(bad == 0, "R5", "full-buffer byte stream", bad, 0);
        launch(32'h0000_0100);
        wait_done(s);
        check(mbit == 257 * 8, "R5", "count 256 exact", mbit, 257 * 8);
    endtask

    task automatic t_busy_ignore;
        int s; int m; logic [31:0] v;
        wr(A_CMD, 32'h0000_0006);
        launch(32'h0000_0028);
        wr(A_CMD, 32'hDEAD_BEEF);
        wr(A_BUF, 32'h1234_5678);
        wr(A_CTRL, 32'h0003_0000);
        wait_done(s);
        check(mbit == 41 * 8, "R7", "transfer length unaffected", mbit, 41 * 8);
        rd(A_CMD, v);
        check(v == 32'h6, "R7", "command write ignored", v, 32'h6);
        rd(A_CTRL, v);
        check(v == 32'h28, "R7", "control write ignored", v, 32'h28);
        rd(A_BUF, v);
        check(v == fillw(0), "R7", "buffer write ignored", v, fillw(0));
        m = mbit;
        repeat (60) @(negedge clk);
        check(mbit == m && cs_n, "R7", "no second transfer", mbit, m);
    endtask

    task automatic t_status;
        logic [31:0] v;
        wr(A_STAT, 32'h1);
        rd(A_STAT, v);
        check(v == 1, "R6", "nonzero write keeps status", v, 1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v);
        check(v == 0, "R6", "zero write clears status", v, 0);
    endtask

    task automatic t_divider;
        int s;
        wr(A_CLK, 32'h3000_0000);
        wr(A_CMD, 32'h0000_009F);
        launch(32'h0000_0000);
        wait_done(s);
        check(min_per == 6, "R8", "sck period at D=3", min_per, 6);
        check(s - cs_rise_cyc + 1 >= 6, "R9", "cs hold at D=3", s - cs_rise_cyc + 1, 6);
        check(tx_cap[0] == 8'h9F, "R8", "byte at slow clock", tx_cap[0], 8'h9F);
        wr(A_CLK, 32'h0000_0000);
        launch(32'h0000_0000);
        wait_done(s);
        check(min_per == 2, "R8", "divider zero acts as one", min_per, 2);
        wr(A_CLK, 32'h1000_0000);
    endtask

    initial begin
        #(8 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_cmd_only();
        t_short_cmd();
        t_write();
        t_read();
        t_rd_zero();
        t_saturate();
        t_busy_ignore();
        t_status();
        t_divider();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule